// File: doc/BRIEF.md
# Sharing-Aware Victim Selector

This block chooses which way of one cache set to evict when a miss needs room. The set is shared by several hardware threads. For every way the block keeps a valid bit, a saturating count of hits since the line arrived, and a mask of the threads that have used the line. The number of threads in the mask gives a two-bit sharing degree. The degree and the hit count are joined into one priority key. The victim is the valid way with the smallest key, so a line used by many threads survives longer than a private line with the same number of hits.

The surrounding cache reports every hit and every fill on the access port: the way, the thread, and whether the access is a fill. It reads `victim_way` whenever it needs a replacement candidate. That output depends only on the stored state, and an access changes the state on the next rising clock edge. Tags, data, coherence and set indexing belong to the surrounding cache.

Top module: `share_aware_victim_sel`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every valid bit, thread mask and hit counter, so `victim_way` reads 0 after it.
- R2: A fill (`acc_valid`=1, `acc_fill`=1) makes the way valid, sets its thread mask to the filling thread alone and sets its hit counter to 0, whatever the way held before.
- R3: A hit (`acc_valid`=1, `acc_fill`=0) on a valid way adds one to its 3-bit hit counter, which saturates at 7 and never wraps.
- R4: A hit sets the accessing thread's bit in the way's mask. The sharing degree follows the number of set bits: 1 thread gives 2'b00 (private), 2 gives 2'b01 (light), 3 gives 2'b10 (heavy), 4 gives 2'b11 (very heavy). Repeated hits by a thread already in the mask leave the degree unchanged.
- R5: The priority of a valid way is the 5-bit value {degree, hit count}, with the degree in bits 4:3. Among valid ways the one with the smallest priority is the victim, so a shared line with 1 hit ranks above a private line with 7 hits.
- R6: If any way is invalid, `victim_way` is the lowest-numbered invalid way.
- R7: When all ways are valid and several share the smallest priority, the lowest-numbered of them is the victim.
- R8: A hit on an invalid way changes nothing. The way stays invalid.
- R9: `victim_way` is a function of the stored state only. An access shows in it only after the next rising clock edge.
- R10: With `acc_valid` low, the state does not change, whatever the other access inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | An access is reported this cycle |
| acc_fill | input | 1 | 1: the access is a fill; 0: the access is a hit |
| acc_way | input | 3 | Way targeted by the access |
| acc_thread | input | 2 | Thread that made the access |
| victim_way | output | 3 | Way to evict on the next miss |

## Verification
The assertions take for granted that `acc_way` always names an existing way and `acc_thread` an existing thread. They also take for granted that the cache reports a hit only for a way it believes is resident. Since a hit on an invalid way is a legal input that must be ignored, that case is still checked. The stimulus keeps to these limits: every way and thread index it drives is in range, and it issues hits on invalid ways only to check that they are ignored. Each access lasts exactly one cycle, and results are sampled a full cycle later.

// File: rtl/share_repl_pkg.sv
package share_repl_pkg;

    // Four sharing levels, kept in the top bits of the priority key.
    typedef enum logic [1:0] {
        SHARE_PRIVATE = 2'b00,
        SHARE_LIGHT   = 2'b01,
        SHARE_HEAVY   = 2'b10,
        SHARE_VHEAVY  = 2'b11
    } share_deg_e;

    localparam int unsigned DEG_W = 2;

    // Maps the number of distinct users of a line to its sharing level.
    function automatic share_deg_e deg_from_count(input int unsigned users);
        share_deg_e deg;
        if (users <= 1)      deg = SHARE_PRIVATE;
        else if (users == 2) deg = SHARE_LIGHT;
        else if (users == 3) deg = SHARE_HEAVY;
        else                 deg = SHARE_VHEAVY;
        return deg;
    endfunction

endpackage

// File: rtl/share_degree_calc.sv
module share_degree_calc
    import share_repl_pkg::*;
#(
    parameter int unsigned NUM_THREADS = 4
) (
    input  logic [NUM_THREADS-1:0] user_mask,
    output logic [DEG_W-1:0]       degree
);
    localparam int unsigned CNT_W = $clog2(NUM_THREADS + 1);

    logic [CNT_W-1:0] users;

    always_comb begin
        users = '0;
        for (int i = 0; i < NUM_THREADS; i++) begin
            users = users + CNT_W'(user_mask[i]);
        end
    end

    assign degree = DEG_W'(deg_from_count(int'(users)));

endmodule

// File: rtl/way_slot.sv
module way_slot
    import share_repl_pkg::*;
#(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned HIT_W       = 3,
    localparam int unsigned TID_W      = $clog2(NUM_THREADS),
    localparam int unsigned PRIO_W     = DEG_W + HIT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_en,
    input  logic              hit_en,
    input  logic [TID_W-1:0]  thread_id,
    output logic              slot_valid,
    output logic [PRIO_W-1:0] slot_prio
);
    localparam logic [HIT_W-1:0] HIT_MAX = '1;

    typedef struct packed {
        logic                   valid;
        logic [NUM_THREADS-1:0] mask;
        logic [HIT_W-1:0]       hits;
    } slot_t;

    slot_t                  st_d, st_q;
    logic [NUM_THREADS-1:0] thread_bit_d;
    logic [DEG_W-1:0]       degree_d;

    assign thread_bit_d = NUM_THREADS'(1) << thread_id;

    always_comb begin
        st_d = st_q;
        if (fill_en) begin
            st_d.valid = 1'b1;
            st_d.mask  = thread_bit_d;
            st_d.hits  = '0;
        end else if (hit_en && st_q.valid) begin
            st_d.mask = st_q.mask | thread_bit_d;
            if (st_q.hits != HIT_MAX) begin
                st_d.hits = st_q.hits + HIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    share_degree_calc #(
        .NUM_THREADS(NUM_THREADS)
    ) u_degree (
        .user_mask(st_q.mask),
        .degree   (degree_d)
    );

    assign slot_valid = st_q.valid;
    assign slot_prio  = {degree_d, st_q.hits};

endmodule

// File: rtl/victim_pick.sv
module victim_pick #(
    parameter int unsigned NUM_WAYS = 8,
    parameter int unsigned PRIO_W   = 5,
    localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0]             way_valid,
    input  logic [NUM_WAYS-1:0][PRIO_W-1:0] way_prio,
    output logic [WAY_W-1:0]                victim
);
    // Cost 0 for an invalid way; {1, prio} for a valid way.
    logic [NUM_WAYS-1:0][PRIO_W:0] cost_d;
    logic [PRIO_W:0]               best_cost_d;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cost
        assign cost_d[w] = way_valid[w] ? {1'b1, way_prio[w]} : '0;
    end

    // Strict compare keeps the lowest index on a tie.
    always_comb begin
        best_cost_d = cost_d[0];
        victim      = '0;
        for (int i = 1; i < NUM_WAYS; i++) begin
            if (cost_d[i] < best_cost_d) begin
                best_cost_d = cost_d[i];
                victim      = WAY_W'(i);
            end
        end
    end

endmodule

// File: rtl/share_aware_victim_sel.sv
module share_aware_victim_sel
    import share_repl_pkg::*;
#(
    parameter int unsigned NUM_WAYS    = 8,
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned HIT_W       = 3,
    localparam int unsigned WAY_W      = $clog2(NUM_WAYS),
    localparam int unsigned TID_W      = $clog2(NUM_THREADS),
    localparam int unsigned PRIO_W     = DEG_W + HIT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic             acc_fill,
    input  logic [WAY_W-1:0] acc_way,
    input  logic [TID_W-1:0] acc_thread,
    output logic [WAY_W-1:0] victim_way
);
    logic [NUM_WAYS-1:0]             fill_en_d;
    logic [NUM_WAYS-1:0]             hit_en_d;
    logic [NUM_WAYS-1:0]             slot_valid;
    logic [NUM_WAYS-1:0][PRIO_W-1:0] slot_prio;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        assign fill_en_d[w] = acc_valid &&  acc_fill && (acc_way == WAY_W'(w));
        assign hit_en_d[w]  = acc_valid && !acc_fill && (acc_way == WAY_W'(w));

        way_slot #(
            .NUM_THREADS(NUM_THREADS),
            .HIT_W      (HIT_W)
        ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .fill_en   (fill_en_d[w]),
            .hit_en    (hit_en_d[w]),
            .thread_id (acc_thread),
            .slot_valid(slot_valid[w]),
            .slot_prio (slot_prio[w])
        );
    end

    victim_pick #(
        .NUM_WAYS(NUM_WAYS),
        .PRIO_W  (PRIO_W)
    ) u_pick (
        .way_valid(slot_valid),
        .way_prio (slot_prio),
        .victim   (victim_way)
    );

endmodule

// File: rtl/share_victim_checker.sv
module share_victim_checker #(
    parameter int unsigned NUM_WAYS = 8,
    parameter int unsigned HIT_W    = 3,
    parameter int unsigned PRIO_W   = 5,
    parameter int unsigned WAY_W    = 3
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             acc_valid,
    input logic                             acc_fill,
    input logic [WAY_W-1:0]                 acc_way,
    input logic [NUM_WAYS-1:0]              slot_valid,
    input logic [NUM_WAYS-1:0][PRIO_W-1:0]  slot_prio,
    input logic [WAY_W-1:0]                 victim_way
);
    localparam logic [HIT_W-1:0] HIT_MAX = '1;

    // R1: reset empties the set
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (slot_valid == '0));

    // R2: a fill leaves a valid way at priority zero
    a_r2_fill_state: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_fill) |=>
            (slot_valid[$past(acc_way)] && (slot_prio[$past(acc_way)] == '0)));

    // R3: a hit below saturation counts up by one
    a_r3_hit_count: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_fill && slot_valid[acc_way] &&
         (slot_prio[acc_way][HIT_W-1:0] != HIT_MAX)) |=>
            (slot_prio[$past(acc_way)][HIT_W-1:0] ==
             $past(slot_prio[acc_way][HIT_W-1:0]) + HIT_W'(1)));

    // R3: a saturated counter does not wrap
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_fill && slot_valid[acc_way] &&
         (slot_prio[acc_way][HIT_W-1:0] == HIT_MAX)) |=>
            (slot_prio[$past(acc_way)][HIT_W-1:0] == HIT_MAX));

    // R4: a hit never lowers the sharing degree
    a_r4_degree_monotone: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_fill && slot_valid[acc_way]) |=>
            (slot_prio[$past(acc_way)][PRIO_W-1:HIT_W] >=
             $past(slot_prio[acc_way][PRIO_W-1:HIT_W])));

    // R8: a hit on an invalid way leaves it invalid
    a_r8_invalid_hit: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_fill && !slot_valid[acc_way]) |=>
            !slot_valid[$past(acc_way)]);

    // R10: no access, no change
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> ($stable(slot_valid) && $stable(slot_prio)));

    // R6: an invalid way is preferred
    a_r6_invalid_first: assert property (@(posedge clk) disable iff (rst)
        (slot_valid != '1) |-> !slot_valid[victim_way]);

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way_chk
        // R5: the victim holds the smallest priority of a full set
        a_r5_min_prio: assert property (@(posedge clk) disable iff (rst)
            (slot_valid == '1) |-> (slot_prio[victim_way] <= slot_prio[w]));

        // R7: on a tie the lower index wins
        a_r7_tie_low: assert property (@(posedge clk) disable iff (rst)
            ((slot_valid == '1) && (slot_prio[w] == slot_prio[victim_way])) |->
                (victim_way <= WAY_W'(w)));

        // R6: no lower invalid way is skipped
        a_r6_lowest_invalid: assert property (@(posedge clk) disable iff (rst)
            (!slot_valid[w] && (slot_valid != '1)) |-> (victim_way <= WAY_W'(w)));
    end

endmodule

bind share_aware_victim_sel share_victim_checker #(
    .NUM_WAYS(NUM_WAYS),
    .HIT_W   (HIT_W),
    .PRIO_W  (PRIO_W),
    .WAY_W   (WAY_W)
) u_share_victim_checker (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_fill  (acc_fill),
    .acc_way   (acc_way),
    .slot_valid(slot_valid),
    .slot_prio (slot_prio),
    .victim_way(victim_way)
);

// File: tb/share_aware_victim_sel_test.sv
`timescale 1ns/1ps
module share_aware_victim_sel_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_valid = 1'b0;
    logic       acc_fill = 1'b0;
    logic [2:0] acc_way = '0;
    logic [1:0] acc_thread = '0;
    logic [2:0] victim_way;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    share_aware_victim_sel uut (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_fill  (acc_fill),
        .acc_way   (acc_way),
        .acc_thread(acc_thread),
        .victim_way(victim_way)
    );

    // Entry: {fill, way, thread, expected victim after the access}
    localparam int NVEC = 20;
    localparam logic [8:0] VEC [NVEC] = '{
        {1'b1, 3'd0, 2'd0, 3'd1}, {1'b1, 3'd1, 2'd1, 3'd2},
        {1'b1, 3'd2, 2'd2, 3'd3}, {1'b1, 3'd3, 2'd3, 3'd4},
        {1'b1, 3'd4, 2'd0, 3'd5}, {1'b1, 3'd5, 2'd1, 3'd6},
        {1'b1, 3'd6, 2'd2, 3'd7}, {1'b1, 3'd7, 2'd3, 3'd0},
        {1'b0, 3'd0, 2'd0, 3'd1}, {1'b0, 3'd1, 2'd1, 3'd2},
        {1'b0, 3'd2, 2'd3, 3'd3}, {1'b0, 3'd3, 2'd0, 3'd4},
        {1'b0, 3'd4, 2'd0, 3'd5}, {1'b0, 3'd5, 2'd1, 3'd6},
        {1'b0, 3'd6, 2'd2, 3'd7}, {1'b0, 3'd7, 2'd3, 3'd0},
        {1'b0, 3'd0, 2'd0, 3'd1}, {1'b1, 3'd1, 2'd2, 3'd1},
        {1'b0, 3'd1, 2'd2, 3'd1}, {1'b0, 3'd1, 2'd3, 3'd4}
    };

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: victim_way=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic access(input logic f, input logic [2:0] w, input logic [1:0] t);
        @(negedge clk);
        acc_valid  = 1'b1;
        acc_fill   = f;
        acc_way    = w;
        acc_thread = t;
        @(negedge clk);
        acc_valid  = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic fill_all(input logic [1:0] t);
        for (int w = 0; w < 8; w++) access(1'b1, 3'(w), t);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 initial reset", victim_way, 3'd0);

        // Table walk: R6 while filling, then R5/R7 with shared and private hits
        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i][8], VEC[i][7:5], VEC[i][4:3]);
            check($sformatf("R5 R6 R7 table entry %0d", i), victim_way, VEC[i][2:0]);
        end

        // R1: reset from a loaded set
        do_reset();
        check("R1 reset after load", victim_way, 3'd0);

        // R9: an access is not visible before the edge
        @(negedge clk);
        acc_valid = 1'b1; acc_fill = 1'b1; acc_way = 3'd0; acc_thread = 2'd0;
        #1;
        check("R9 before edge", victim_way, 3'd0);
        @(negedge clk);
        acc_valid = 1'b0;
        check("R9 after edge", victim_way, 3'd1);

        // R8: hit on invalid way 1 is ignored
        access(1'b0, 3'd1, 2'd1);
        check("R8 hit on invalid way", victim_way, 3'd1);
        access(1'b1, 3'd1, 2'd1);
        check("R2 fill way 1", victim_way, 3'd2);
        access(1'b1, 3'd3, 2'd2);
        check("R6 lowest invalid", victim_way, 3'd2);

        // R3: saturation of the hit counter
        do_reset();
        fill_all(2'd0);
        for (int w = 1; w < 8; w++)
            for (int k = 0; k < 6; k++) access(1'b0, 3'(w), 2'd0);
        for (int k = 0; k < 7; k++) access(1'b0, 3'd0, 2'd0);
        check("R3 count to 7", victim_way, 3'd1);
        access(1'b0, 3'd0, 2'd0);
        check("R3 saturate at 7", victim_way, 3'd1);

        // R4/R5: degree ordering against hit counts
        do_reset();
        fill_all(2'd0);
        for (int w = 2; w < 8; w++) begin
            access(1'b0, 3'(w), 2'd1);
            access(1'b0, 3'(w), 2'd2);
            access(1'b0, 3'(w), 2'd3);
        end
        access(1'b0, 3'd0, 2'd1);
        for (int k = 0; k < 7; k++) access(1'b0, 3'd1, 2'd0);
        check("R5 shared 1 hit above private 7 hits", victim_way, 3'd1);
        access(1'b0, 3'd1, 2'd1);
        check("R4 two threads light", victim_way, 3'd0);
        access(1'b0, 3'd0, 2'd2);
        check("R4 three threads heavy", victim_way, 3'd1);
        access(1'b0, 3'd1, 2'd1);
        check("R4 repeat thread no raise", victim_way, 3'd1);
        access(1'b0, 3'd0, 2'd3);
        access(1'b0, 3'd1, 2'd2);
        access(1'b0, 3'd1, 2'd3);
        check("R7 tie among very heavy", victim_way, 3'd0);

        // R10: inputs without acc_valid do nothing
        @(negedge clk);
        acc_valid = 1'b0; acc_fill = 1'b1; acc_way = 3'd2; acc_thread = 2'd1;
        repeat (3) @(negedge clk);
        check("R10 idle fill ignored", victim_way, 3'd0);
        acc_fill = 1'b0;

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule